// File: doc/BRIEF.md
# Function-Unit Dependency Matrix

This block tracks ordering hazards between in-flight function units in an out-of-order core. It holds a square bit array with one row and one column for each function unit. The row number is the unit's identity, so the same index serves as the ordering tag and no tag is stored or compared. Each cell carries two flags. The first means "this row's unit must wait for the column's unit to produce before it may read operands" (read-after-write). The second means "this row's unit must wait for the column's unit to read before it may write its result" (write-after-read).

When an instruction issues to a unit, the issue logic supplies two vectors: the units that will write its sources, and the units that still have to read its destination. The selected row is loaded from these vectors, with the self bit removed. When a unit retires, the matrix clears that unit's column in every row in the same cycle. Each row reduces through a wide NOR to a `may_read` flag and a `may_write` flag for its unit. Every dependency is a single unary bit, so several rows can be loaded at once and several columns can be cleared at once.

Top module: `fu_dep_matrix`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every cell is zero and all `may_read` and `may_write` bits are 1.
- R2: A unit whose bit in `issue_sel` is 1 at a clock edge has its whole row of read-after-write flags replaced by `raw_vec` from that edge. Bit j of `raw_vec` is the wait on unit j. The new state is visible on the outputs after that edge.
- R3: In the same way, the selected row's write-after-read flags are replaced by `war_vec`, where bit j is the wait on unit j.
- R4: The diagonal is always masked. A unit never waits on itself, even when its own bit is set in `raw_vec` or `war_vec`.
- R5: `may_read[i]` is 1 exactly when row i holds no read-after-write flag.
- R6: `may_write[i]` is 1 exactly when row i holds no write-after-read flag.
- R7: A 1 in bit j of `retire` clears both flags in column j of every row at that edge. Several columns may be cleared in one cycle.
- R8: When an issue load and a retire clear hit the same cell at the same edge, the cell ends up cleared.
- R9: An edge with `issue_sel` and `retire` both all-zero leaves every cell unchanged, whatever values `raw_vec` and `war_vec` carry.
- R10: A row whose `issue_sel` bit is 0 never gains a flag. Its `may_read` and `may_write` can only rise until that unit issues again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_sel | input | NUM_FU | Unary select of the row or rows to load |
| raw_vec | input | NUM_FU | Producers the issuing unit must wait on before reading |
| war_vec | input | NUM_FU | Readers the issuing unit must wait on before writing |
| retire | input | NUM_FU | Units retiring this cycle; clears their columns |
| may_read | output | NUM_FU | Per unit: no read-after-write wait pending |
| may_write | output | NUM_FU | Per unit: no write-after-read wait pending |

## Verification
On every cycle the assertions check the following:
- each row load, for both flag kinds, including the self-bit mask and the clear-over-load priority;
- the column wipe on retire;
- the state holding still on an idle edge;
- readiness being unable to fall on a row that did not issue.

Only the bench's scenarios can show end-to-end dependency chains, where a consumer becomes readable only after its producer retires, and a later writer becomes writable only after the earlier reader leaves. The same holds for reissue replacing a stale row, and for long mixed sequences compared against an independent model.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
   typedef struct packed {
      logic raw;   // waits on column unit before reading
      logic war;   // waits on column unit before writing
   } dep_cell_t;

   localparam int MIN_FU = 2;
   localparam int MAX_FU = 64;
endpackage

// File: rtl/fdm_cell.sv
module fdm_cell
   import fdm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  logic      clear,
   input  dep_cell_t d,
   output dep_cell_t q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (clear) q <= '0;       // retire beats a simultaneous load
      else if (load)  q <= d;
   end
endmodule

// File: rtl/fdm_row_nor.sv
module fdm_row_nor #(
   parameter int N = 8
) (
   input  logic [N-1:0] raw_row,
   input  logic [N-1:0] war_row,
   output logic         may_read,
   output logic         may_write
);
   assign may_read  = ~|raw_row;
   assign may_write = ~|war_row;
endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix
   import fdm_pkg::*;
#(
   parameter int NUM_FU = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_FU-1:0] issue_sel,
   input  logic [NUM_FU-1:0] raw_vec,
   input  logic [NUM_FU-1:0] war_vec,
   input  logic [NUM_FU-1:0] retire,
   output logic [NUM_FU-1:0] may_read,
   output logic [NUM_FU-1:0] may_write
);
   localparam int CELLS = NUM_FU * NUM_FU;

   generate
      if (NUM_FU < MIN_FU || NUM_FU > MAX_FU) begin : g_bad_size
         $error("fu_dep_matrix: NUM_FU out of range");
      end
   endgenerate

   // flattened state, row r occupies bits [r*NUM_FU +: NUM_FU]
   logic [CELLS-1:0] raw_flat;
   logic [CELLS-1:0] war_flat;

   for (genvar r = 0; r < NUM_FU; r++) begin : g_row
      for (genvar c = 0; c < NUM_FU; c++) begin : g_col
         if (r == c) begin : g_diag
            assign raw_flat[r*NUM_FU+c] = 1'b0;
            assign war_flat[r*NUM_FU+c] = 1'b0;
         end else begin : g_cell
            dep_cell_t cell_d;
            dep_cell_t cell_q;
            assign cell_d.raw = raw_vec[c];
            assign cell_d.war = war_vec[c];
            fdm_cell u_cell (
               .clk   (clk),
               .rst_n (rst_n),
               .load  (issue_sel[r]),
               .clear (retire[c]),
               .d     (cell_d),
               .q     (cell_q)
            );
            assign raw_flat[r*NUM_FU+c] = cell_q.raw;
            assign war_flat[r*NUM_FU+c] = cell_q.war;
         end
      end

      fdm_row_nor #(.N(NUM_FU)) u_nor (
         .raw_row   (raw_flat[r*NUM_FU +: NUM_FU]),
         .war_row   (war_flat[r*NUM_FU +: NUM_FU]),
         .may_read  (may_read[r]),
         .may_write (may_write[r])
      );
   end
endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
   parameter int NUM_FU = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_FU-1:0]        issue_sel,
   input logic [NUM_FU-1:0]        raw_vec,
   input logic [NUM_FU-1:0]        war_vec,
   input logic [NUM_FU-1:0]        retire,
   input logic [NUM_FU-1:0]        may_read,
   input logic [NUM_FU-1:0]        may_write,
   input logic [NUM_FU*NUM_FU-1:0] raw_flat,
   input logic [NUM_FU*NUM_FU-1:0] war_flat
);
   a_r1_reset_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> ((&may_read) && (&may_write)));

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_sel == '0 && retire == '0) |=> ($stable(raw_flat) && $stable(war_flat)));

   for (genvar i = 0; i < NUM_FU; i++) begin : g_unit
      localparam logic [NUM_FU-1:0] SELF = NUM_FU'(1) << i;

      a_r2_raw_load: assert property (@(posedge clk) disable iff (!rst_n)
         issue_sel[i] |=> (may_read[i] == ~|($past(raw_vec) & ~$past(retire) & ~SELF)));

      a_r3_war_load: assert property (@(posedge clk) disable iff (!rst_n)
         issue_sel[i] |=> (may_write[i] == ~|($past(war_vec) & ~$past(retire) & ~SELF)));

      a_r4_self_masked: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_sel[i] && raw_vec == SELF && war_vec == SELF) |=> (may_read[i] && may_write[i]));

      a_r10_ready_monotone: assert property (@(posedge clk) disable iff (!rst_n)
         (!issue_sel[i] && may_read[i] && may_write[i]) |=> (may_read[i] && may_write[i]));

      for (genvar j = 0; j < NUM_FU; j++) begin : g_col
         a_r7_column_clear: assert property (@(posedge clk) disable iff (!rst_n)
            retire[j] |=> (!raw_flat[i*NUM_FU+j] && !war_flat[i*NUM_FU+j]));

         a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_sel[i] && retire[j] && (raw_vec[j] || war_vec[j]))
            |=> (!raw_flat[i*NUM_FU+j] && !war_flat[i*NUM_FU+j]));
      end
   end
endmodule

bind fu_dep_matrix fdm_checker #(.NUM_FU(NUM_FU)) u_chk (.*);

// File: tb/sim_fu_dep_matrix.sv
module sim_fu_dep_matrix;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [N-1:0] issue_sel, raw_vec, war_vec, retire;
   logic [N-1:0] may_read, may_write;

   bit ref_raw [N][N];
   bit ref_war [N][N];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fu_dep_matrix #(.NUM_FU(N)) u0 (
      .clk(clk), .rst_n(rst_n), .issue_sel(issue_sel), .raw_vec(raw_vec),
      .war_vec(war_vec), .retire(retire), .may_read(may_read), .may_write(may_write)
   );

   function automatic logic [N-1:0] oh(int k);
      return N'(1) << k;
   endfunction

   function automatic logic [N-1:0] ref_rd();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) begin
         v[i] = 1'b1;
         for (int j = 0; j < N; j++) if (ref_raw[i][j]) v[i] = 1'b0;
      end
      return v;
   endfunction

   function automatic logic [N-1:0] ref_wr();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) begin
         v[i] = 1'b1;
         for (int j = 0; j < N; j++) if (ref_war[i][j]) v[i] = 1'b0;
      end
      return v;
   endfunction

   task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic check_bit(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            ref_raw[i][j] = 1'b0;
            ref_war[i][j] = 1'b0;
         end
   endtask

   // drive at negedge, model the edge, compare at the next negedge
   task automatic cycle(string tag, logic [N-1:0] sel, logic [N-1:0] rv,
                        logic [N-1:0] wv, logic [N-1:0] ret);
      issue_sel = sel; raw_vec = rv; war_vec = wv; retire = ret;
      @(posedge clk);
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            if (ret[j]) begin
               ref_raw[i][j] = 1'b0;
               ref_war[i][j] = 1'b0;
            end else if (sel[i] && i != j) begin
               ref_raw[i][j] = rv[j];
               ref_war[i][j] = wv[j];
            end
         end
      @(negedge clk);
      check(tag, "may_read", may_read, ref_rd());
      check(tag, "may_write", may_write, ref_wr());
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; issue_sel = '0; raw_vec = '0; war_vec = '0; retire = '0;
      model_reset();
      repeat (3) @(negedge clk);
      check("R1", "may_read in reset", may_read, '1);
      check("R1", "may_write in reset", may_write, '1);
      rst_n = 1'b1;
      cycle("R1", '0, '0, '0, '0);
      check("R1", "may_read after reset", may_read, '1);

      // R2/R3: unit 3 waits on producers 0,1 and reader 5
      cycle("R2", oh(3), oh(0) | oh(1), oh(5), '0);
      check_bit("R2", "may_read[3]", may_read[3], 1'b0);
      check_bit("R3", "may_write[3]", may_write[3], 1'b0);

      // R4: self bits only
      cycle("R4", oh(4), oh(4), oh(4), '0);
      check_bit("R4", "may_read[4]", may_read[4], 1'b1);
      check_bit("R4", "may_write[4]", may_write[4], 1'b1);

      // chain 0 -> 1 -> 2, with 2 also writing after 0 reads
      cycle("R5", oh(1), oh(0), '0, '0);
      cycle("R6", oh(2), oh(1), oh(0), '0);
      check_bit("R5", "may_read[2] blocked", may_read[2], 1'b0);
      check_bit("R6", "may_write[2] blocked", may_write[2], 1'b0);
      cycle("R7", '0, '0, '0, oh(0));
      check_bit("R7", "may_read[1] after retire 0", may_read[1], 1'b1);
      check_bit("R6", "may_write[2] after retire 0", may_write[2], 1'b1);
      check_bit("R5", "may_read[2] still blocked", may_read[2], 1'b0);
      check_bit("R5", "may_read[3] still blocked", may_read[3], 1'b0);
      cycle("R7", '0, '0, '0, oh(1) | oh(5));
      check_bit("R7", "may_read[2] after retire 1", may_read[2], 1'b1);
      check_bit("R7", "may_read[3] after retire 1", may_read[3], 1'b1);
      check_bit("R7", "may_write[3] after retire 5", may_write[3], 1'b1);

      // R8: load and clear on the same cell
      cycle("R8", oh(6), oh(7), oh(7), oh(7));
      check_bit("R8", "may_read[6]", may_read[6], 1'b1);
      check_bit("R8", "may_write[6]", may_write[6], 1'b1);

      // R9: idle edge with noisy vectors
      cycle("R2", oh(6), oh(7), '0, '0);
      cycle("R9", '0, '1, '1, '0);
      check_bit("R9", "may_read[6] held", may_read[6], 1'b0);
      check("R9", "may_write held", may_write, '1);

      // R2: reissue replaces the stale row
      cycle("R2", oh(6), oh(0), '0, '0);
      cycle("R2", '0, '0, '0, oh(0));
      check_bit("R2", "may_read[6] stale bit gone", may_read[6], 1'b1);

      // R10: long mixed traffic against the model
      for (int k = 0; k < 600; k++) begin
         logic [N-1:0] s, rt;
         s  = ($urandom_range(0, 2) == 0) ? oh($urandom_range(0, N-1)) : '0;
         rt = ($urandom_range(0, 3) == 0) ? oh($urandom_range(0, N-1)) : '0;
         if ($urandom_range(0, 15) == 0) rt = rt | oh($urandom_range(0, N-1));
         cycle("R10", s, N'($urandom), N'($urandom), rt);
      end

      cycle("R7", '0, '0, '0, '1);
      check("R7", "all retired may_read", may_read, '1);
      check("R7", "all retired may_write", may_write, '1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule